// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block carries out the state changes a processor core makes when it takes a trap and when it comes back from one. The core keeps a stack of nested trap levels. For each level the block holds a saved record: a packed trap-state word, the program counter, the next program counter and the trap type. When a trap request arrives with a 9-bit trap type, the block saves the live state into the slot for the current level. It then switches to a privileged processor state, moves the register window pointer if the trap belongs to a window-management class, writes the trap vector into the low part of the trap base register and redirects PC and next-PC there. Finally it raises the trap level, or marks the red (reset/error) state near the top of the stack.

A trap-return request reads the record for the level below, lowers the level and puts every saved field back. It has two flavours. The retry flavour resumes at the saved PC. The done flavour resumes at the saved next-PC. The core's ordinary register writes reach the architectural registers this block owns through a state-write port. A trap requested when the stack is already full puts the block into a fatal error state, which only reset clears.

Top module: `trap_entry_unit`

## Requirements
- R1: After a synchronous active-low reset, the outputs read as follows: trap level 0, processor state 0x024 (privileged bit 2 and red bit 5 set), PC, next-PC and trap base 0, condition codes and address-space identifier 0, window pointer 0, current trap type 0, error state low.
- R2: Trap entry stores a record in the slot indexed by the current trap level. The record holds a 40-bit word, the current PC and next-PC, and the trap type. The word is laid out as condition codes [39:32], address-space identifier [31:24], zero [23:20], processor state ANDed with 0xF3F [19:8], and window pointer zero-extended [7:0]. Whenever the trap level is nonzero, `cur_tt` shows the trap type stored in slot (level-1).
- R3: After trap entry the processor state is 0x015 (alternate-globals bit 0, privileged bit 2 and FP-enable bit 4 set). If the level before entry was MAXTL-1 or higher, it is 0x035 instead, with the red bit 5 also set.
- R4: Trap entry adjusts the window pointer modulo NWIN, based on the pre-entry value. Trap type 0x024 subtracts 1. A type with bits [8:6] = 3'b010 becomes pointer minus `cansave` minus 2. A type with bits [8:6] = 3'b011 adds 1. Every other type leaves it unchanged.
- R5: Trap entry replaces bits [14:0] of the trap base register with {level>1, trap type, 5'b0}, using the level before entry. It loads PC with that vector and next-PC with vector+4. All of these are visible in the cycle after the request.
- R6: Trap entry below MAXTL raises the trap level by exactly 1. The level never exceeds MAXTL.
- R7: A trap request at level MAXTL sets the error state and changes nothing else. Once the error state is set, every trap, return and write request is ignored until reset.
- R8: A return with `ret_done` = 0 (retry) loads PC from the saved PC and next-PC from the saved next-PC. A return with `ret_done` = 1 loads PC from the saved next-PC and next-PC from saved next-PC + 4.
- R9: A return at a nonzero level lowers the level by 1. It restores condition codes, address-space identifier, processor state and window pointer from the word in slot (level-1).
- R10: A return request at trap level 0 is ignored.
- R11: A trap request takes priority over a return request, and a return request takes priority over a state write in the same cycle. A request that loses is dropped.
- R12: A state write loads the processor state ANDed with 0xF3F and sets trap-base bits [14:0] to zero. It clamps the written trap level to MAXTL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Trap type of the request |
| cansave | input | CWP_W | Count of windows that can be saved, used by spill traps |
| ret_req | input | 1 | Return from the current trap level |
| ret_done | input | 1 | 1 = resume at saved next-PC, 0 = retry at saved PC |
| wr_en | input | 1 | Write the architectural registers from the wr_* inputs |
| wr_ccr | input | 8 | Condition codes to write |
| wr_asi | input | 8 | Address-space identifier to write |
| wr_pstate | input | 12 | Processor state to write (masked) |
| wr_cwp | input | CWP_W | Window pointer to write |
| wr_tl | input | TL_W | Trap level to write (clamped) |
| wr_tba | input | ADDR_W | Trap base to write; bits [14:0] are not used |
| wr_pc | input | ADDR_W | PC to write |
| wr_npc | input | ADDR_W | Next-PC to write |
| pc | output | ADDR_W | Current PC |
| npc | output | ADDR_W | Current next-PC |
| tbr | output | ADDR_W | Trap base register, including the last vector offset |
| pstate | output | 12 | Processor state |
| cwp | output | CWP_W | Current window pointer |
| tl | output | TL_W | Current trap level |
| ccr | output | 8 | Condition codes |
| asi | output | 8 | Address-space identifier |
| cur_tt | output | 9 | Trap type saved for the current level, 0 at level 0 |
| err_state | output | 1 | Fatal error: trap taken at the maximum level |

## Verification
The bench builds the block with NWIN = 8, MAXTL = 5 and ADDR_W = 32. With these values it can apply every one of the 512 trap types, each from a different mix of window pointer, can-save count and starting level 0 to 2. That sweep covers all window classes, both settings of vector bit 14, and both return flavours. A stack of only five levels lets the bench fill it completely, unwind it level by level, and reach the red-state entry and the fatal error within a few cycles.

// File: rtl/trap_pkg.sv
// Package: shared constants and helpers for the trap entry/return sequencer.
// Assumes a 12-bit processor state and a 9-bit trap type.
package trap_pkg;

    localparam int PS_W   = 12;
    localparam int TT_W   = 9;
    localparam int TSW_W  = 40;

    // Processor-state bit positions
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;

    localparam logic [PS_W-1:0] PS_KEEP_MASK = 12'hF3F;
    localparam logic [PS_W-1:0] PS_RESET_VAL = 12'h024;
    localparam logic [PS_W-1:0] PS_ON_ENTRY  = 12'h015;

    // Trap classes that move the window pointer
    localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
    localparam logic [2:0]      GRP_SPILL    = 3'b010;
    localparam logic [2:0]      GRP_FILL     = 3'b011;

    typedef enum logic [1:0] {
        WIN_HOLD  = 2'd0,
        WIN_DEC   = 2'd1,
        WIN_SPILL = 2'd2,
        WIN_INC   = 2'd3
    } win_op_e;

    // Decode the window action a trap type demands
    function automatic win_op_e win_op_of(input logic [TT_W-1:0] tt);
        if (tt == TT_CLEAN_WIN)        return WIN_DEC;
        else if (tt[8:6] == GRP_SPILL) return WIN_SPILL;
        else if (tt[8:6] == GRP_FILL)  return WIN_INC;
        else                           return WIN_HOLD;
    endfunction

endpackage

// File: rtl/trap_win_adj.sv
// Module: window pointer adjustment for trap entry.
// Does: picks the post-entry window pointer from the trap class.
// Assumes: NWIN is a power of two, so modulo arithmetic is plain
// truncation to CWP_W bits.
module trap_win_adj
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cwp_cur,
    input  logic [CWP_W-1:0] cansave,
    input  logic [TT_W-1:0]  tt,
    output logic [CWP_W-1:0] cwp_next
);

    localparam logic [CWP_W-1:0] ONE = CWP_W'(1);
    localparam logic [CWP_W-1:0] TWO = CWP_W'(2);

    win_op_e op;

    // Select the window action for this trap type
    always_comb begin
        op = win_op_of(tt);
        unique case (op)
            WIN_DEC:   cwp_next = cwp_cur - ONE;
            WIN_SPILL: cwp_next = cwp_cur - cansave - TWO;
            WIN_INC:   cwp_next = cwp_cur + ONE;
            default:   cwp_next = cwp_cur;
        endcase
    end

endmodule

// File: rtl/trap_vec_gen.sv
// Module: trap vector former.
// Does: overlays {level>1, trap type, 5'b0} on the low 15 bits of the
// trap base register. Assumes ADDR_W > 15.
module trap_vec_gen
    import trap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int TL_W   = 3
) (
    input  logic [ADDR_W-1:0] tbr_cur,
    input  logic [TL_W-1:0]   tl_cur,
    input  logic [TT_W-1:0]   tt,
    output logic [ADDR_W-1:0] vec
);

    localparam logic [TL_W-1:0] TL_ONE = TL_W'(1);

    logic nested;

    // Build the vector from base, nesting flag and trap type
    always_comb begin
        nested = (tl_cur > TL_ONE);
        vec    = {tbr_cur[ADDR_W-1:15], nested, tt, 5'b00000};
    end

endmodule

// File: rtl/trap_state_stack.sv
// Module: per-level trap record storage.
// Does: one record per trap level (state word, PC, next-PC, trap type);
// a single write port and a combinational read port.
// Assumes: reads with an index at or above DEPTH return zero.
module trap_state_stack
    import trap_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [TSW_W-1:0]  wword,
    input  logic [ADDR_W-1:0] wpc,
    input  logic [ADDR_W-1:0] wnpc,
    input  logic [TT_W-1:0]   wtt,
    input  logic [IDX_W-1:0]  ridx,
    output logic [TSW_W-1:0]  rword,
    output logic [ADDR_W-1:0] rpc,
    output logic [ADDR_W-1:0] rnpc,
    output logic [TT_W-1:0]   rtt
);

    logic [DEPTH-1:0][TSW_W-1:0]  word_all;
    logic [DEPTH-1:0][ADDR_W-1:0] pc_all;
    logic [DEPTH-1:0][ADDR_W-1:0] npc_all;
    logic [DEPTH-1:0][TT_W-1:0]   tt_all;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TSW_W-1:0]  word_q;
        logic [ADDR_W-1:0] pc_q;
        logic [ADDR_W-1:0] npc_q;
        logic [TT_W-1:0]   tt_q;

        // Capture the record when this slot is addressed for write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                pc_q   <= '0;
                npc_q  <= '0;
                tt_q   <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                word_q <= wword;
                pc_q   <= wpc;
                npc_q  <= wnpc;
                tt_q   <= wtt;
            end
        end

        assign word_all[g] = word_q;
        assign pc_all[g]   = pc_q;
        assign npc_all[g]  = npc_q;
        assign tt_all[g]   = tt_q;
    end

    // Select the record named by the read index
    always_comb begin
        rword = '0;
        rpc   = '0;
        rnpc  = '0;
        rtt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == IDX_W'(i)) begin
                rword = word_all[i];
                rpc   = pc_all[i];
                rnpc  = npc_all[i];
                rtt   = tt_all[i];
            end
        end
    end

    // R2: a record is only written to a slot that exists
    p_slot_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (widx < IDX_W'(DEPTH)));

endmodule

// File: rtl/trap_entry_unit.sv
// Module: trap entry and return sequencer (top).
// Does: owns PC, next-PC, trap base, processor state, window pointer,
// trap level, condition codes and address-space identifier. On a trap it
// saves them into the current level's record and vectors. On a return it
// restores them from the level below.
// Assumes: NWIN is a power of two with NWIN <= 256, MAXTL >= 2, ADDR_W > 15.
// Priority per cycle is trap, then return, then state write.
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NWIN   = 8,
    parameter int MAXTL  = 5,
    localparam int CWP_W = $clog2(NWIN),
    localparam int TL_W  = $clog2(MAXTL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [8:0]        trap_type,
    input  logic [CWP_W-1:0]  cansave,
    input  logic              ret_req,
    input  logic              ret_done,
    input  logic              wr_en,
    input  logic [7:0]        wr_ccr,
    input  logic [7:0]        wr_asi,
    input  logic [11:0]       wr_pstate,
    input  logic [CWP_W-1:0]  wr_cwp,
    input  logic [TL_W-1:0]   wr_tl,
    input  logic [ADDR_W-1:0] wr_tba,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_npc,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] npc,
    output logic [ADDR_W-1:0] tbr,
    output logic [11:0]       pstate,
    output logic [CWP_W-1:0]  cwp,
    output logic [TL_W-1:0]   tl,
    output logic [7:0]        ccr,
    output logic [7:0]        asi,
    output logic [8:0]        cur_tt,
    output logic              err_state
);

    localparam logic [TL_W-1:0]   TL_TOP    = TL_W'(MAXTL);
    localparam logic [TL_W-1:0]   TL_RED_AT = TL_W'(MAXTL - 1);
    localparam logic [TL_W-1:0]   TL_ONE    = TL_W'(1);
    localparam logic [ADDR_W-1:0] STEP4     = ADDR_W'(4);

    logic [ADDR_W-1:0] pc_q, npc_q, tbr_q;
    logic [PS_W-1:0]   ps_q;
    logic [CWP_W-1:0]  cwp_q;
    logic [TL_W-1:0]   tl_q;
    logic [7:0]        ccr_q, asi_q;
    logic              err_q;

    logic              take_trap, trap_fatal, take_ret, take_wr;
    logic [ADDR_W-1:0] vec;
    logic [CWP_W-1:0]  cwp_trap;
    logic [TSW_W-1:0]  save_word;
    logic [PS_W-1:0]   ps_entry;
    logic [TL_W-1:0]   rd_idx;
    logic [TSW_W-1:0]  rd_word;
    logic [ADDR_W-1:0] rd_pc, rd_npc;
    logic [TT_W-1:0]   rd_tt;

    // Decode which single event this cycle carries
    always_comb begin
        take_trap  = trap_req && !err_q && (tl_q != TL_TOP);
        trap_fatal = trap_req && !err_q && (tl_q == TL_TOP);
        take_ret   = !trap_req && ret_req && !err_q && (tl_q != '0);
        take_wr    = !trap_req && !ret_req && wr_en && !err_q;
    end

    // Pack the live state into the saved trap-state word
    always_comb begin
        save_word = {ccr_q, asi_q, 4'b0000, ps_q & PS_KEEP_MASK, 8'(cwp_q)};
        ps_entry  = PS_ON_ENTRY;
        if (tl_q >= TL_RED_AT) ps_entry[PS_RED] = 1'b1;
        rd_idx    = tl_q - TL_ONE;
    end

    trap_vec_gen #(
        .ADDR_W (ADDR_W),
        .TL_W   (TL_W)
    ) vec_i (
        .tbr_cur (tbr_q),
        .tl_cur  (tl_q),
        .tt      (trap_type),
        .vec     (vec)
    );

    trap_win_adj #(
        .NWIN (NWIN)
    ) win_i (
        .cwp_cur  (cwp_q),
        .cansave  (cansave),
        .tt       (trap_type),
        .cwp_next (cwp_trap)
    );

    trap_state_stack #(
        .DEPTH  (MAXTL),
        .ADDR_W (ADDR_W),
        .IDX_W  (TL_W)
    ) stack_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (take_trap),
        .widx  (tl_q),
        .wword (save_word),
        .wpc   (pc_q),
        .wnpc  (npc_q),
        .wtt   (trap_type),
        .ridx  (rd_idx),
        .rword (rd_word),
        .rpc   (rd_pc),
        .rnpc  (rd_npc),
        .rtt   (rd_tt)
    );

    // Architectural state update for trap, return and write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            npc_q <= '0;
            tbr_q <= '0;
            ps_q  <= PS_RESET_VAL;
            cwp_q <= '0;
            tl_q  <= '0;
            ccr_q <= '0;
            asi_q <= '0;
            err_q <= 1'b0;
        end else if (take_trap) begin
            tbr_q <= vec;
            pc_q  <= vec;
            npc_q <= vec + STEP4;
            ps_q  <= ps_entry;
            cwp_q <= cwp_trap;
            tl_q  <= tl_q + TL_ONE;
        end else if (trap_fatal) begin
            err_q <= 1'b1;
        end else if (take_ret) begin
            tl_q  <= rd_idx;
            ccr_q <= rd_word[39:32];
            asi_q <= rd_word[31:24];
            ps_q  <= rd_word[19:8] & PS_KEEP_MASK;
            cwp_q <= rd_word[CWP_W-1:0];
            if (ret_done) begin
                pc_q  <= rd_npc;
                npc_q <= rd_npc + STEP4;
            end else begin
                pc_q  <= rd_pc;
                npc_q <= rd_npc;
            end
        end else if (take_wr) begin
            pc_q  <= wr_pc;
            npc_q <= wr_npc;
            tbr_q <= {wr_tba[ADDR_W-1:15], 15'b0};
            ps_q  <= wr_pstate & PS_KEEP_MASK;
            cwp_q <= wr_cwp;
            tl_q  <= (wr_tl > TL_TOP) ? TL_TOP : wr_tl;
            ccr_q <= wr_ccr;
            asi_q <= wr_asi;
        end
    end

    // Drive the outputs from the owned registers
    always_comb begin
        pc        = pc_q;
        npc       = npc_q;
        tbr       = tbr_q;
        pstate    = ps_q;
        cwp       = cwp_q;
        tl        = tl_q;
        ccr       = ccr_q;
        asi       = asi_q;
        err_state = err_q;
        cur_tt    = (tl_q == '0) ? '0 : rd_tt;
    end

    // R6: the level stays within the stack
    p_tl_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tl_q <= TL_TOP);

    // R6: an accepted trap raises the level by one
    p_tl_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (tl_q == $past(tl_q) + TL_ONE));

    // R3: entry leaves the core privileged with FP and alternate globals on
    p_entry_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (ps_q[PS_PRIV] && ps_q[PS_PEF] && ps_q[PS_AG]));

    // R5: next-PC follows the vector by one instruction
    p_npc_after_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (npc_q == pc_q + STEP4) && (pc_q == tbr_q));

    // R7: the error state holds and freezes the level
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> (err_q && $stable(tl_q)));

    // R9: an accepted return lowers the level by one
    p_ret_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_ret |=> (tl_q == $past(tl_q) - TL_ONE));

endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;

    localparam int ADDR_W = 32;
    localparam int NWIN   = 8;
    localparam int MAXTL  = 5;
    localparam int CWP_W  = 3;
    localparam int TL_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_req = 1'b0;
    logic [8:0]        trap_type = '0;
    logic [CWP_W-1:0]  cansave = '0;
    logic              ret_req = 1'b0;
    logic              ret_done = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_ccr = '0;
    logic [7:0]        wr_asi = '0;
    logic [11:0]       wr_pstate = '0;
    logic [CWP_W-1:0]  wr_cwp = '0;
    logic [TL_W-1:0]   wr_tl = '0;
    logic [ADDR_W-1:0] wr_tba = '0;
    logic [ADDR_W-1:0] wr_pc = '0;
    logic [ADDR_W-1:0] wr_npc = '0;
    logic [ADDR_W-1:0] pc, npc, tbr;
    logic [11:0]       pstate;
    logic [CWP_W-1:0]  cwp;
    logic [TL_W-1:0]   tl;
    logic [7:0]        ccr, asi;
    logic [8:0]        cur_tt;
    logic              err_state;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trap_entry_unit #(
        .ADDR_W (ADDR_W),
        .NWIN   (NWIN),
        .MAXTL  (MAXTL)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_req  (trap_req),
        .trap_type (trap_type),
        .cansave   (cansave),
        .ret_req   (ret_req),
        .ret_done  (ret_done),
        .wr_en     (wr_en),
        .wr_ccr    (wr_ccr),
        .wr_asi    (wr_asi),
        .wr_pstate (wr_pstate),
        .wr_cwp    (wr_cwp),
        .wr_tl     (wr_tl),
        .wr_tba    (wr_tba),
        .wr_pc     (wr_pc),
        .wr_npc    (wr_npc),
        .pc        (pc),
        .npc       (npc),
        .tbr       (tbr),
        .pstate    (pstate),
        .cwp       (cwp),
        .tl        (tl),
        .ccr       (ccr),
        .asi       (asi),
        .cur_tt    (cur_tt),
        .err_state (err_state)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_wr(input logic [7:0] c, input logic [7:0] a, input logic [11:0] p,
                          input logic [CWP_W-1:0] w, input logic [TL_W-1:0] l,
                          input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] pcv);
        wr_ccr = c; wr_asi = a; wr_pstate = p; wr_cwp = w; wr_tl = l;
        wr_tba = base; wr_pc = pcv; wr_npc = pcv + 32'd4;
    endtask

    task automatic write_state(input logic [7:0] c, input logic [7:0] a, input logic [11:0] p,
                               input logic [CWP_W-1:0] w, input logic [TL_W-1:0] l,
                               input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] pcv);
        @(negedge clk);
        set_wr(c, a, p, w, l, base, pcv);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take_trap(input logic [8:0] t, input logic [CWP_W-1:0] cs);
        @(negedge clk);
        trap_req = 1'b1; trap_type = t; cansave = cs;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    task automatic take_ret(input logic done);
        @(negedge clk);
        ret_req = 1'b1; ret_done = done;
        @(negedge clk);
        ret_req = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] vec_of(input logic [ADDR_W-1:0] base,
                                                 input int lvl, input logic [8:0] t);
        return {base[31:15], (lvl > 1) ? 1'b1 : 1'b0, t, 5'b0};
    endfunction

    function automatic logic [CWP_W-1:0] win_of(input logic [CWP_W-1:0] c,
                                                input logic [CWP_W-1:0] cs,
                                                input logic [8:0] t);
        if (t == 9'h024)          return c - 3'd1;
        else if (t[8:6] == 3'b010) return c - cs - 3'd2;
        else if (t[8:6] == 3'b011) return c + 3'd1;
        else                       return c;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stimulus
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ex_pc  [0:MAXTL];
        logic [11:0]       ex_ps  [0:MAXTL];
        logic [ADDR_W-1:0] hold_pc;

        do_reset();
        // R1: reset values
        chk("R1 tl", 64'(tl), 64'd0);
        chk("R1 pstate", 64'(pstate), 64'h024);
        chk("R1 pc", 64'(pc), 64'd0);
        chk("R1 npc", 64'(npc), 64'd0);
        chk("R1 cwp", 64'(cwp), 64'd0);
        chk("R1 cur_tt", 64'(cur_tt), 64'd0);
        chk("R1 err", 64'(err_state), 64'd0);

        // R10: return at level 0 leaves everything alone
        take_ret(1'b1);
        chk("R10 tl", 64'(tl), 64'd0);
        chk("R10 pc", 64'(pc), 64'd0);
        chk("R10 pstate", 64'(pstate), 64'h024);

        // R12: write masks processor state and clears low trap-base bits
        write_state(8'h00, 8'h00, 12'hFFF, 3'd0, 3'd7, 32'hFFFF_FFFF, 32'h0);
        chk("R12 pstate", 64'(pstate), 64'hF3F);
        chk("R12 tbr", 64'(tbr), 64'hFFFF_8000);
        chk("R12 tl clamp", 64'(tl), 64'd5);

        // Sweep every trap type from varied states (R2 R3 R4 R5 R6 R8 R9)
        base = 32'hABCD_8000;
        for (int t = 0; t < 512; t++) begin
            logic [8:0]        tt9;
            logic [CWP_W-1:0]  c, cs;
            logic [7:0]        cc, aa;
            logic [11:0]       ps;
            logic [ADDR_W-1:0] pcv, v;
            int                lvl;
            tt9 = 9'(t);
            cs  = tt9[5:3];
            c   = tt9[2:0] ^ tt9[5:3];
            cc  = tt9[7:0];
            aa  = ~tt9[7:0];
            ps  = 12'(t * 37) & 12'hF3F;
            pcv = 32'h1000_0000 + 32'(t * 8);
            lvl = t % 3;
            write_state(cc, aa, ps, c, 3'(lvl), base, pcv);
            take_trap(tt9, cs);
            v = vec_of(base, lvl, tt9);
            chk("R5 pc", 64'(pc), 64'(v));
            chk("R5 npc", 64'(npc), 64'(v + 32'd4));
            chk("R5 tbr", 64'(tbr), 64'(v));
            chk("R3 pstate", 64'(pstate), 64'h015);
            chk("R4 cwp", 64'(cwp), 64'(win_of(c, cs, tt9)));
            chk("R6 tl", 64'(tl), 64'(lvl + 1));
            chk("R2 cur_tt", 64'(cur_tt), 64'(tt9));
            take_ret(tt9[0]);
            chk("R9 tl", 64'(tl), 64'(lvl));
            chk("R9 ccr", 64'(ccr), 64'(cc));
            chk("R9 asi", 64'(asi), 64'(aa));
            chk("R9 pstate", 64'(pstate), 64'(ps));
            chk("R9 cwp", 64'(cwp), 64'(c));
            if (tt9[0]) begin
                chk("R8 done pc", 64'(pc), 64'(pcv + 32'd4));
                chk("R8 done npc", 64'(npc), 64'(pcv + 32'd8));
            end else begin
                chk("R8 retry pc", 64'(pc), 64'(pcv));
                chk("R8 retry npc", 64'(npc), 64'(pcv + 32'd4));
            end
        end

        // Fill the stack, then unwind it with retry returns (R3 R5 R6 R8 R9)
        do_reset();
        base = 32'h4000_0000;
        write_state(8'h5A, 8'h80, 12'h001, 3'd2, 3'd0, base, 32'h2000);
        ex_pc[0] = 32'h2000;
        ex_ps[0] = 12'h001;
        for (int k = 0; k < MAXTL; k++) begin
            take_trap(9'(32'h40 + k), 3'd0);
            ex_pc[k+1] = vec_of(base, k, 9'(32'h40 + k));
            ex_ps[k+1] = (k >= MAXTL - 1) ? 12'h035 : 12'h015;
            chk("R6 depth tl", 64'(tl), 64'(k + 1));
            chk("R3 depth pstate", 64'(pstate), 64'(ex_ps[k+1]));
            chk("R5 depth pc", 64'(pc), 64'(ex_pc[k+1]));
            chk("R7 no err", 64'(err_state), 64'd0);
        end
        for (int k = MAXTL - 1; k >= 0; k--) begin
            take_ret(1'b0);
            chk("R9 unwind tl", 64'(tl), 64'(k));
            chk("R8 unwind pc", 64'(pc), 64'(ex_pc[k]));
            chk("R8 unwind npc", 64'(npc), 64'(ex_pc[k] + 32'd4));
            chk("R9 unwind pstate", 64'(pstate), 64'(ex_ps[k]));
            chk("R9 unwind cwp", 64'(cwp), 64'd2);
            chk("R2 unwind cur_tt", 64'(cur_tt), (k == 0) ? 64'd0 : 64'(32'h40 + k - 1));
        end

        // Trap at the top level is fatal and sticky (R7)
        for (int k = 0; k < MAXTL; k++) take_trap(9'h041, 3'd0);
        hold_pc = pc;
        take_trap(9'h050, 3'd0);
        chk("R7 err", 64'(err_state), 64'd1);
        chk("R7 tl held", 64'(tl), 64'(MAXTL));
        chk("R7 pc held", 64'(pc), 64'(hold_pc));
        take_ret(1'b1);
        chk("R7 ret ignored", 64'(tl), 64'(MAXTL));
        write_state(8'h00, 8'h00, 12'h000, 3'd0, 3'd0, 32'h0, 32'h0);
        chk("R7 wr ignored", 64'(tl), 64'(MAXTL));
        do_reset();
        chk("R1 err cleared", 64'(err_state), 64'd0);

        // Priority among simultaneous requests (R11)
        write_state(8'h11, 8'h22, 12'h004, 3'd1, 3'd1, 32'h8000_0000, 32'h3000);
        @(negedge clk);
        set_wr(8'hEE, 8'hEE, 12'h000, 3'd5, 3'd0, 32'h0, 32'h0);
        trap_req = 1'b1; trap_type = 9'h100; cansave = 3'd0;
        ret_req = 1'b1; ret_done = 1'b0; wr_en = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R11 trap wins tl", 64'(tl), 64'd2);
        chk("R11 trap wins pc", 64'(pc), 64'(vec_of(32'h8000_0000, 1, 9'h100)));
        @(negedge clk);
        ret_req = 1'b0; wr_en = 1'b0;
        chk("R11 ret beats wr tl", 64'(tl), 64'd1);
        chk("R11 ret beats wr ccr", 64'(ccr), 64'h11);
        chk("R11 ret beats wr pc", 64'(pc), 64'h3000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule